// File: doc/BRIEF.md
# Pipelined Set-Associative Cache Array

This block is the storage and lookup part of a first-level cache. It accepts a read or write of one 32-bit word in every cycle that is not stalled. It answers with a hit flag, and with read data on a read hit, after a fixed number of cycles. The access runs through three registered steps. The first step registers the request and splits the address into set, word and tag. The second step compares the tags of every way in the set. The third step drives the response. In the default variant, the data words of all ways are read while the tags are compared, and the output step keeps only the matching word. In the low-power variant, one step is added: the tag compare finishes first, and in the next cycle only the matching way's data bank is enabled.

A write is never committed in the cycle of its own tag compare. It is committed one step later, and only after a hit has been confirmed, so a write that misses leaves the array untouched. A miss is only reported. Lines enter the array through a separate fill port. Each fill places one whole line into the way picked by a round-robin pointer kept per set. A stall input holds every stage.

Top module: `pcache_pipe`

## Requirements
- R1: While reset is asserted, rsp_valid is low. After reset, every access reports a miss until a fill has loaded the addressed line.
- R2: In the default variant, a request sampled at a rising edge with stall low gives a response three cycles later: it is presented in cycle 0 and answered in cycle 3, given no stall in between. Every accepted request gives exactly one response, in acceptance order. A cycle with req_valid low gives no response.
- R3: When stall stays low, a new request can be accepted in every cycle, including long runs of back-to-back hits.
- R4: Address bits [3:2] select the word in the line, bits [9:4] select the set and bits [31:10] form the tag. A read hit returns the stored word. rsp_rdata is zero on a miss and on every write response.
- R5: A write hit replaces only the addressed word. A write miss leaves every line unchanged, which later reads show.
- R6: A read that directly follows a write to the same word returns the newly written data.
- R7: While stall is high, no request is accepted, all stages and the response outputs hold their values, and rsp_valid is low. Responses resume once stall falls.
- R8: A fill writes all four words and the tag of a line into the way given by a per-set pointer. The pointer starts at way 0 after reset and advances by one on each fill to that set, wrapping after way 3. The line that was in that way is lost.
- R9: When a fill lands on the same set and way at the same edge as a pending write commit, the fill wins, and the line holds the filled data.
- R10: With LOW_POWER set to 1, the hit latency is four cycles. Every response carries the same hit flag and data as in the default variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Holds every stage and blocks acceptance |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Word address, bits [31:2] of the byte address |
| req_wdata | input | 32 | Write data |
| fill_valid | input | 1 | Line fill present this cycle |
| fill_addr | input | 28 | Line address, bits [31:4] of the byte address |
| fill_line | input | 128 | Line contents, word k at bits [32k+31:32k] |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Access hit |
| rsp_rdata | output | 32 | Read data on a read hit, zero otherwise |

## Verification
Back-to-back reads of every word of every filled way show whether the set, word and way selection and the full-rate acceptance are right. A write followed at once by reads of the same word tells a working forward path apart from a stale array read. A random mix of hits, misses, writes and stall cycles tells a correct fixed latency and ordering apart from dropped, duplicated or shifted responses, and a write miss that corrupts a line. Directed fills check the round-robin eviction and the case where a fill and a write commit meet on the same line. Both variants run on the same stimulus.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

   typedef enum logic {
      ACC_RD = 1'b0,
      ACC_WR = 1'b1
   } acc_kind_e;

   // lowest set bit position of a (nominally one-hot) vector
   function automatic int unsigned onehot_to_idx(input logic [31:0] vec);
      int unsigned idx;
      idx = 0;
      for (int i = 31; i >= 0; i--) begin
         if (vec[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/pcache_tags.sv
module pcache_tags #(
   parameter int SETS  = 64,
   parameter int WAYS  = 4,
   parameter int TAG_W = 22
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(SETS)-1:0]  lk_set,
   input  logic [TAG_W-1:0]         lk_tag,
   output logic [WAYS-1:0]          lk_hit,
   input  logic                     fill_en,
   input  logic [$clog2(SETS)-1:0]  fill_set,
   input  logic [TAG_W-1:0]         fill_tag,
   output logic [$clog2(WAYS)-1:0]  fill_way
);
   localparam int WAY_W = $clog2(WAYS);

   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAY_W-1:0] vic_q [SETS];

   assign fill_way = vic_q[fill_set];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            vic_q[s] <= '0;
         end
      end else if (fill_en) begin
         vld_q[fill_set][fill_way] <= 1'b1;
         vic_q[fill_set]           <= fill_way + WAY_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign lk_hit[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
   end

   // R8: a filled way becomes valid and the set's pointer steps on
   a_r8_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> vld_q[$past(fill_set)][$past(fill_way)]);
   a_r8_victim_steps: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vic_q[$past(fill_set)] == $past(fill_way) + WAY_W'(1)));

endmodule

// File: rtl/pcache_data.sv
module pcache_data #(
   parameter int SETS       = 64,
   parameter int WAYS       = 4,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [$clog2(SETS)-1:0]            rd_set,
   input  logic [$clog2(LINE_WORDS)-1:0]      rd_word,
   input  logic [WAYS-1:0]                    rd_way_en,
   output logic [WAYS-1:0][DATA_W-1:0]        rd_words,
   input  logic                               wr_en,
   input  logic [$clog2(SETS)-1:0]            wr_set,
   input  logic [$clog2(WAYS)-1:0]            wr_way,
   input  logic [$clog2(LINE_WORDS)-1:0]      wr_word,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic                               fill_en,
   input  logic [$clog2(SETS)-1:0]            fill_set,
   input  logic [$clog2(WAYS)-1:0]            fill_way,
   input  logic [DATA_W*LINE_WORDS-1:0]       fill_line
);
   localparam int WAY_W = $clog2(WAYS);

   for (genvar w = 0; w < WAYS; w++) begin : g_bank
      logic [DATA_W-1:0] bank_q [SETS][LINE_WORDS];

      always_ff @(posedge clk) begin
         if (wr_en && wr_way == WAY_W'(w)) bank_q[wr_set][wr_word] <= wr_data;
         if (fill_en && fill_way == WAY_W'(w)) begin
            for (int k = 0; k < LINE_WORDS; k++)
               bank_q[fill_set][k] <= fill_line[k*DATA_W +: DATA_W];
         end
      end

      // a disabled bank drives zero, standing for an idle array
      assign rd_words[w] = rd_way_en[w] ? bank_q[rd_set][rd_word] : '0;
   end

   // R9: the pipeline never commits into the line a fill is writing
   a_r9_fill_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fill_en) |-> !(wr_set == fill_set && wr_way == fill_way));

endmodule

// File: rtl/pcache_pipe.sv
module pcache_pipe #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   parameter int LINE_WORDS = 4,
   parameter bit LOW_POWER  = 1'b0
) (
   input  logic                                                      clk,
   input  logic                                                      rst_n,
   input  logic                                                      stall,
   input  logic                                                      req_valid,
   input  logic                                                      req_write,
   input  logic [ADDR_W-1:$clog2(DATA_W/8)]                          req_addr,
   input  logic [DATA_W-1:0]                                         req_wdata,
   input  logic                                                      fill_valid,
   input  logic [ADDR_W-1:$clog2(DATA_W/8)+$clog2(LINE_WORDS)]       fill_addr,
   input  logic [DATA_W*LINE_WORDS-1:0]                              fill_line,
   output logic                                                      rsp_valid,
   output logic                                                      rsp_hit,
   output logic [DATA_W-1:0]                                         rsp_rdata
);
   import pcache_pkg::*;

   localparam int BYTE_W   = $clog2(DATA_W/8);
   localparam int WORD_W   = $clog2(LINE_WORDS);
   localparam int SET_W    = $clog2(SETS);
   localparam int WAY_W    = $clog2(WAYS);
   localparam int LINE_OFF = BYTE_W + WORD_W;
   localparam int TAG_W    = ADDR_W - LINE_OFF - SET_W;

   if (WAYS < 2 || WAYS > 32 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two from 2 to 32");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0 || TAG_W < 1) begin : g_bad_width
      $error("DATA_W must be whole bytes and the address must leave a tag");
   end

   // ---------------- stage 1: register request, split address ----------------
   logic              s1_v;
   acc_kind_e         s1_kind;
   logic [TAG_W-1:0]  s1_tag;
   logic [SET_W-1:0]  s1_set;
   logic [WORD_W-1:0] s1_word;
   logic [DATA_W-1:0] s1_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     s1_v <= 1'b0;
      else if (!stall) s1_v <= req_valid;
   end

   always_ff @(posedge clk) begin
      if (!stall && req_valid) begin
         s1_kind  <= req_write ? ACC_WR : ACC_RD;
         s1_tag   <= req_addr[ADDR_W-1 -: TAG_W];
         s1_set   <= req_addr[LINE_OFF +: SET_W];
         s1_word  <= req_addr[BYTE_W +: WORD_W];
         s1_wdata <= req_wdata;
      end
   end

   // ---------------- tag store and fill decode ----------------
   logic [SET_W-1:0] fill_set;
   logic [TAG_W-1:0] fill_tag;
   logic [WAY_W-1:0] fill_way;
   logic [WAYS-1:0]  hitv;

   assign fill_set = fill_addr[LINE_OFF +: SET_W];
   assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

   pcache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_set  (s1_set),
      .lk_tag  (s1_tag),
      .lk_hit  (hitv),
      .fill_en (fill_valid),
      .fill_set(fill_set),
      .fill_tag(fill_tag),
      .fill_way(fill_way)
   );

   // ---------------- stage 2: compare result ----------------
   logic              s2_v, s2_kill;
   acc_kind_e         s2_kind;
   logic [SET_W-1:0]  s2_set;
   logic [WORD_W-1:0] s2_word;
   logic [DATA_W-1:0] s2_wdata;
   logic [WAYS-1:0]   s2_hitv;
   logic              s2_hit;
   logic [WAY_W-1:0]  s2_way;
   logic              fill_on_s1, fill_on_s2, wr_commit;

   // a fill replacing the matched line before the access finishes voids the match
   assign fill_on_s1 = fill_valid && fill_set == s1_set && hitv[fill_way];
   assign fill_on_s2 = fill_valid && fill_set == s2_set && s2_hitv[fill_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_kill <= 1'b0;
      end else if (!stall) begin
         s2_v    <= s1_v;
         s2_kill <= fill_on_s1;
      end else begin
         s2_kill <= s2_kill | fill_on_s2;
      end
   end

   always_ff @(posedge clk) begin
      if (!stall) begin
         s2_kind  <= s1_kind;
         s2_set   <= s1_set;
         s2_word  <= s1_word;
         s2_wdata <= s1_wdata;
         s2_hitv  <= hitv;
      end
   end

   assign s2_hit    = s2_v && (|s2_hitv) && !s2_kill;
   assign s2_way    = WAY_W'(onehot_to_idx(32'(s2_hitv)));
   // write lands one step after its compare; a same-line fill takes precedence
   assign wr_commit = !stall && s2_hit && s2_kind == ACC_WR && !fill_on_s2;

   // ---------------- data store ----------------
   logic [SET_W-1:0]              rd_set;
   logic [WORD_W-1:0]             rd_word;
   logic [WAYS-1:0]               rd_way_en;
   logic [WAYS-1:0][DATA_W-1:0]   rd_words;

   pcache_data #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (rd_set),
      .rd_word  (rd_word),
      .rd_way_en(rd_way_en),
      .rd_words (rd_words),
      .wr_en    (wr_commit),
      .wr_set   (s2_set),
      .wr_way   (s2_way),
      .wr_word  (s2_word),
      .wr_data  (s2_wdata),
      .fill_en  (fill_valid),
      .fill_set (fill_set),
      .fill_way (fill_way),
      .fill_line(fill_line)
   );

   // ---------------- variant: where the data read sits ----------------
   logic              pre_v, pre_hit;
   logic [DATA_W-1:0] pre_rdata;

   if (!LOW_POWER) begin : g_parallel
      logic [WAYS-1:0][DATA_W-1:0] s2_data;
      logic                        byp;

      assign rd_set    = s1_set;
      assign rd_word   = s1_word;
      assign rd_way_en = '1;
      // the write committing now is not yet visible to the read it passes
      assign byp = wr_commit && s2_set == s1_set && s2_word == s1_word;

      always_ff @(posedge clk) begin
         if (!stall) begin
            for (int w = 0; w < WAYS; w++)
               s2_data[w] <= (byp && s2_way == WAY_W'(w)) ? s2_wdata : rd_words[w];
         end
      end

      assign pre_v     = s2_v;
      assign pre_hit   = s2_hit;
      assign pre_rdata = (s2_hit && s2_kind == ACC_RD) ? s2_data[s2_way] : '0;
   end else begin : g_serial
      logic              s3_v, s3_hit;
      logic [DATA_W-1:0] s3_rdata, rd_or;

      assign rd_set    = s2_set;
      assign rd_word   = s2_word;
      assign rd_way_en = (s2_hit && s2_kind == ACC_RD) ? s2_hitv : '0;

      always_comb begin
         rd_or = '0;
         for (int w = 0; w < WAYS; w++) rd_or = rd_or | rd_words[w];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s3_v     <= 1'b0;
            s3_hit   <= 1'b0;
            s3_rdata <= '0;
         end else if (!stall) begin
            s3_v     <= s2_v;
            s3_hit   <= s2_hit;
            s3_rdata <= rd_or;
         end
      end

      assign pre_v     = s3_v;
      assign pre_hit   = s3_hit;
      assign pre_rdata = s3_rdata;
   end

   // ---------------- output stage ----------------
   logic              out_v, out_hit;
   logic [DATA_W-1:0] out_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v     <= 1'b0;
         out_hit   <= 1'b0;
         out_rdata <= '0;
      end else if (!stall) begin
         out_v     <= pre_v;
         out_hit   <= pre_hit;
         out_rdata <= pre_rdata;
      end
   end

   assign rsp_valid = out_v && !stall;
   assign rsp_hit   = out_hit;
   assign rsp_rdata = out_rdata;

   // R7: a stalled edge leaves the response unchanged
   a_r7_stall_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(rsp_hit) && $stable(rsp_rdata)));

   if (!LOW_POWER) begin : g_lat3
      // R2: an accepted request answers three cycles later when nothing stalls
      a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !stall) ##1 !stall ##1 !stall ##1 !stall |-> rsp_valid);
   end else begin : g_lat4
      // R10: one extra cycle in the serial variant
      a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !stall) ##1 !stall ##1 !stall ##1 !stall ##1 !stall |-> rsp_valid);
   end

endmodule

// File: tb/pcache_pipe_tb.sv
`timescale 1ns/1ps
module pcache_pipe_tb;
   localparam int SETS = 64;
   localparam int WAYS = 4;
   localparam int LW   = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n, stall, req_valid, req_write, fill_valid;
   logic [31:2]  req_addr;
   logic [31:0]  req_wdata;
   logic [31:4]  fill_addr;
   logic [127:0] fill_line;
   logic         d_v, d_hit, p_v, p_hit;
   logic [31:0]  d_dat, p_dat;

   pcache_pipe #(.LOW_POWER(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .stall(stall), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .fill_valid(fill_valid), .fill_addr(fill_addr),
      .fill_line(fill_line), .rsp_valid(d_v), .rsp_hit(d_hit), .rsp_rdata(d_dat));

   pcache_pipe #(.LOW_POWER(1'b1)) u_dut_lp (
      .clk(clk), .rst_n(rst_n), .stall(stall), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .fill_valid(fill_valid), .fill_addr(fill_addr),
      .fill_line(fill_line), .rsp_valid(p_v), .rsp_hit(p_hit), .rsp_rdata(p_dat));

   // bench model of the array contents
   logic [21:0] m_tag [SETS][WAYS];
   bit          m_vld [SETS][WAYS];
   logic [31:0] m_dat [SETS][WAYS][LW];
   int          m_vic [SETS];
   // expected responses in flight, index 2 = default output, 3 = serial output
   bit          e_v   [4];
   bit          e_hit [4];
   logic [31:0] e_dat [4];

   int    checks = 0, fails = 0;
   bit    done = 1'b0;
   string cur = "R1";

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int find_way(int s, logic [21:0] t);
      for (int w = 0; w < WAYS; w++)
         if (m_vld[s][w] && m_tag[s][w] == t) return w;
      return -1;
   endfunction

   task automatic cmp_out(string tag, int slot, logic v, logic h, logic [31:0] d);
      bit ev;
      ev = e_v[slot] && !stall;
      chk({tag, " valid"}, {31'b0, v}, {31'b0, ev});
      if (ev) begin
         chk({tag, " hit"}, {31'b0, h}, {31'b0, e_hit[slot]});
         chk({tag, " data"}, d, e_dat[slot]);
      end
   endtask

   task automatic step(bit st, bit rv, bit rw, logic [21:0] t, int s, int wd, logic [31:0] wdat,
                       bit fv, logic [21:0] ft, int fs, logic [127:0] fl);
      int          w;
      bit          nh;
      logic [31:0] nd;
      @(negedge clk);
      stall = st; req_valid = rv; req_write = rw;
      req_addr = {t, 6'(s), 2'(wd)}; req_wdata = wdat;
      fill_valid = fv; fill_addr = {ft, 6'(fs)}; fill_line = fl;
      #1;
      cmp_out(cur, 2, d_v, d_hit, d_dat);
      cmp_out({cur, " R10"}, 3, p_v, p_hit, p_dat);
      if (!st) begin
         nh = 1'b0; nd = '0;
         if (rv) begin
            w = find_way(s, t);
            nh = (w >= 0);
            if (w >= 0) begin
               if (rw) m_dat[s][w][wd] = wdat;
               else    nd = m_dat[s][w][wd];
            end
         end
         for (int i = 3; i > 0; i--) begin
            e_v[i] = e_v[i-1]; e_hit[i] = e_hit[i-1]; e_dat[i] = e_dat[i-1];
         end
         e_v[0] = rv; e_hit[0] = nh; e_dat[0] = nd;
      end
      if (fv) begin
         w = m_vic[fs];
         m_tag[fs][w] = ft; m_vld[fs][w] = 1'b1;
         for (int k = 0; k < LW; k++) m_dat[fs][w][k] = fl[k*32 +: 32];
         m_vic[fs] = (w + 1) % WAYS;
      end
   endtask

   task automatic idle();                                  step(0,0,0,'0,0,0,'0,0,'0,0,'0); endtask
   task automatic rd(logic [21:0] t, int s, int wd);       step(0,1,0,t,s,wd,'0,0,'0,0,'0); endtask
   task automatic wr(logic [21:0] t, int s, int wd, logic [31:0] d); step(0,1,1,t,s,wd,d,0,'0,0,'0); endtask
   task automatic fill(logic [21:0] t, int s, logic [127:0] l);      step(0,0,0,'0,0,0,'0,1,t,s,l); endtask
   task automatic drain();                                 repeat (5) idle(); endtask

   function automatic logic [127:0] rnd_line();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      logic [21:0] ta, tb;
      logic [127:0] ln;
      void'($urandom(32'd20240611));
      for (int s = 0; s < SETS; s++) begin
         m_vic[s] = 0;
         for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
      end
      for (int i = 0; i < 4; i++) begin e_v[i] = 0; e_hit[i] = 0; e_dat[i] = '0; end
      rst_n = 1'b0; stall = 0; req_valid = 0; req_write = 0; req_addr = '0;
      req_wdata = '0; fill_valid = 0; fill_addr = '0; fill_line = '0;
      repeat (3) @(negedge clk);
      #1;
      // R1: quiet during reset
      chk("R1 reset valid", {31'b0, d_v}, 32'd0);
      chk("R1 reset valid R10", {31'b0, p_v}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: nothing is resident yet
      cur = "R1";
      rd(22'd1, 0, 0); rd(22'd5, 3, 2); wr(22'd9, 7, 1, 32'h1234_5678);
      drain();

      // R8: four fills per set land in ways 0..3
      cur = "R8";
      for (int s = 0; s < 8; s++)
         for (int w = 0; w < WAYS; w++) fill(22'(s*8 + w + 1), s, rnd_line());
      drain();

      // R3 R4: back-to-back reads over every word of every way
      cur = "R3 R4";
      for (int s = 0; s < 8; s++)
         for (int w = 0; w < WAYS; w++)
            for (int k = 0; k < LW; k++) rd(22'(s*8 + w + 1), s, k);
      drain();

      // R6: read right behind a write to the same word
      cur = "R6";
      wr(22'd11, 1, 2, 32'hCAFE_0001); rd(22'd11, 1, 2); rd(22'd11, 1, 2);
      wr(22'd20, 2, 0, 32'hCAFE_0002); rd(22'd20, 2, 0); rd(22'd20, 2, 1);
      drain();

      // R5: write miss changes nothing, write hit touches one word
      cur = "R5";
      wr(22'h3FFF05, 5, 1, 32'hBAD0_BAD0);
      wr(22'd42, 5, 3, 32'h0000_5555);
      idle(); idle();
      for (int w = 0; w < WAYS; w++)
         for (int k = 0; k < LW; k++) rd(22'(5*8 + w + 1), 5, k);
      drain();

      // R7: requests offered during stall are refused
      cur = "R7";
      rd(22'd1, 0, 0);
      step(1,1,0,22'd2,0,1,'0,0,'0,0,'0);
      step(1,1,1,22'd2,0,1,32'hFFFF_FFFF,0,'0,0,'0);
      step(1,0,0,'0,0,0,'0,0,'0,0,'0);
      rd(22'd2, 0, 1);
      drain();

      // R2 R7: random reads, writes, misses and stalls
      cur = "R2 R7 random";
      for (int i = 0; i < 1500; i++) begin
         int s, w, k;
         bit st, rv, rw;
         logic [21:0] t;
         st = ($urandom % 100) < 15;
         rv = ($urandom % 100) < 80;
         rw = ($urandom % 100) < 40;
         s  = $urandom % 8;
         w  = $urandom % 5;
         k  = $urandom % LW;
         t  = (w < 4) ? m_tag[s][w] : 22'h3FFF00 + 22'(s);
         step(st, rv, rw, t, s, k, $urandom, 0, '0, 0, '0);
      end
      drain();

      // R8: fifth fill to set 0 evicts way 0
      cur = "R8 evict";
      ln = rnd_line();
      fill(22'h2000, 0, ln);
      drain();
      rd(22'd1, 0, 0); rd(22'h2000, 0, 3); rd(22'd2, 0, 0);
      drain();

      // R9: fill meets the commit edge of a write to the same line
      cur = "R9";
      ta = m_tag[1][m_vic[1]];
      tb = 22'h2001;
      ln = rnd_line();
      wr(ta, 1, 0, 32'hDEAD_BEEF);
      idle();
      fill(tb, 1, ln);
      drain();
      rd(tb, 1, 0); rd(ta, 1, 0);
      drain();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule